// File: doc/BRIEF.md
# I2C Slave Presence Poller

The block finds out when one device on an I2C bus is ready to answer. After a start pulse it probes a single 7-bit address again and again. Each probe is an address-only transaction: a START, the address with a read bit, one acknowledge clock and a STOP. A probe that is not acknowledged is not reported. The block waits a programmable number of SCL cycles and then probes again. When the device acknowledges, the block raises a one-cycle ready pulse and stops. The block also watches for a device that holds SCL low. If SCL stays low for too many SCL cycles while the block has released it, the block raises a timeout pulse, releases the bus and stops.

All timing comes from `scl_tick`, a strobe at four times the SCL rate. One SCL cycle is four ticks. The bus is open drain. A high `scl_oe` or `sda_oe` means the block pulls that line low. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake. Polling runs only while `en` is high. `en` stands for master operation with monitoring enabled.

Top module: `i2c_presence_poller`

## Requirements
- R1: After reset `busy`, `ready`, `timeout`, `scl_oe` and `sda_oe` are all low.
- R2: A `go` pulse starts polling only when `en` is high and the block is idle. `addr` is latched at that moment, so later changes to `addr` do not affect the probes.
- R3: Each probe has this order on the bus:
  - a START;
  - seven address bits, most significant first, each driven while SCL is low;
  - a read/write bit of 1;
  - a ninth clock with SDA released, during which SDA is sampled while SCL is high;
  - a STOP.
- R4: A probe that sees SDA high on the ninth clock (NACK) raises no output. The next probe follows, and the time from one START to the next is (44 + 4*pause) ticks. With a pause value of 0 the next START follows the STOP at once.
- R5: A probe that sees SDA low on the ninth clock (ACK) gives a `ready` pulse one clock long. `busy` falls in that same cycle, and no further probe starts.
- R6: While the block has released SCL but SCL reads low, the sequence waits. A stretch shorter than the limit does not stop the probe from completing.
- R7: A continuous stretch of (tmo+1)*4 ticks gives a `timeout` pulse one clock long. The count restarts each time the stretch ends.
- R8: On a timeout, both lines are released, `busy` drops, and no probe starts until the next `go`.
- R9: Lowering `en` aborts polling and no `ready` is given. If the block is driving a line at that moment, it first completes a STOP on the bus and then goes idle. Otherwise it goes idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Polling enable; low aborts |
| go | input | 1 | Start pulse; latches `addr` |
| addr | input | 7 | Slave address to probe |
| pause | input | 4 | SCL cycles to wait between probes |
| tmo | input | 8 | Stretch limit in SCL cycles, minus one |
| scl_tick | input | 1 | Quarter-SCL-period strobe |
| scl_i | input | 1 | SCL line as read |
| sda_i | input | 1 | SDA line as read |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| ready | output | 1 | Slave acknowledged (one-cycle pulse) |
| timeout | output | 1 | SCL stretch limit exceeded (one-cycle pulse) |
| busy | output | 1 | Polling in progress |

## Verification
The bench counts probes and measures the START-to-START interval for several pause values, including 0. A wrong pause count, or a stray wait state between STOP and START, changes that interval by clock cycles. It checks that an acknowledged probe is the last one and that the captured byte equals the address latched at `go`. A design that kept polling, or that read `addr` live, would fail here. The stretch tests hold SCL low twice, once past a short limit and once for less than a long one. The short case times the `timeout` pulse against its window. The long case catches a design that never stalls or that counts stretch time cumulatively. A mid-probe disable must produce a STOP and no `ready`. An enable-less `go` must leave the block idle.

// File: rtl/i2c_pp_pkg.sv
package i2c_pp_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_BIT   = 3'd2,
    S_STOP  = 3'd3,
    S_PAUSE = 3'd4
  } pp_state_t;
endpackage

// File: rtl/i2c_pp_stretch.sv
module i2c_pp_stretch #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          stall,
  input  logic [TW-1:0] tmo,
  output logic          expire
);
  localparam int CW = TW + 2;
  logic [CW-1:0] cnt;

  // ticks of continuous stall; cleared whenever the line comes up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!stall) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assign expire = stall && tick && (cnt == {tmo, 2'b11});

  // R7: an expiry is only possible after a stall that was already running
  a_r7_expire_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(stall));
endmodule

// File: rtl/i2c_pp_pause.sv
module i2c_pp_pause #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [PW-1:0] pause,
  output logic          last
);
  localparam int CW = PW + 2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= {pause, 2'b00};
    else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/i2c_pp_drive.sv
module i2c_pp_drive
  import i2c_pp_pkg::*;
#(
  parameter int AW = 7
) (
  input  pp_state_t     st,
  input  logic [1:0]    ph,
  input  logic [3:0]    idx,
  input  logic [AW-1:0] addr_q,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int NB = AW + 1;  // address bits plus read bit
  logic cur;

  always_comb begin
    if (idx < 4'(AW)) cur = addr_q[AW - 1 - int'(idx)];
    else              cur = 1'b1;
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        sda_oe = (ph != 2'd0);
        scl_oe = (ph >= 2'd2);
      end
      S_BIT: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = (idx < 4'(NB)) ? !cur : 1'b0;
      end
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = (ph <= 2'd1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_presence_poller.sv
module i2c_presence_poller
  import i2c_pp_pkg::*;
#(
  parameter int AW = 7,
  parameter int PW = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          go,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] pause,
  input  logic [TW-1:0] tmo,
  input  logic          scl_tick,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          ready,
  output logic          timeout,
  output logic          busy
);
  localparam logic [3:0] ACK_IDX = 4'(AW + 1);

  pp_state_t     st;
  logic [1:0]    ph;
  logic [3:0]    idx;
  logic [AW-1:0] addr_q;
  logic          acked, abort;
  logic          owned, stall, step, expire, p_last, p_load, stop_end;

  assign owned    = (st == S_START) || (st == S_BIT) || (st == S_STOP);
  assign stall    = owned && !scl_oe && !scl_i;
  assign step     = scl_tick && !stall;
  assign stop_end = (st == S_STOP) && step && (ph == 2'd3);
  assign p_load   = stop_end && !acked && !abort;
  assign busy     = (st != S_IDLE);

  i2c_pp_drive #(.AW(AW)) u_drive (
    .st(st), .ph(ph), .idx(idx), .addr_q(addr_q),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2c_pp_stretch #(.TW(TW)) u_stretch (
    .clk(clk), .rst_n(rst_n), .tick(scl_tick), .stall(stall),
    .tmo(tmo), .expire(expire)
  );

  i2c_pp_pause #(.PW(PW)) u_pause (
    .clk(clk), .rst_n(rst_n), .tick(scl_tick), .load(p_load),
    .pause(pause), .last(p_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; idx <= '0; addr_q <= '0;
      acked <= 1'b0; abort <= 1'b0; ready <= 1'b0; timeout <= 1'b0;
    end else begin
      ready   <= stop_end && acked && !abort;
      timeout <= expire;
      if (expire) begin
        st <= S_IDLE; ph <= '0;
      end else if (!en && st != S_IDLE && !abort) begin
        if (st == S_STOP) abort <= 1'b1;
        else if (st == S_PAUSE || (st == S_START && ph == 2'd0)) begin
          st <= S_IDLE; ph <= '0;
        end else begin
          st <= S_STOP; ph <= '0; abort <= 1'b1;
        end
      end else begin
        case (st)
          S_IDLE: if (go && en) begin
            st <= S_START; ph <= '0; addr_q <= addr; abort <= 1'b0;
          end
          S_START: if (step) begin
            ph <= ph + 2'd1;
            acked <= 1'b0;
            if (ph == 2'd3) begin st <= S_BIT; idx <= '0; end
          end
          S_BIT: if (step) begin
            ph <= ph + 2'd1;
            if (ph == 2'd2 && idx == ACK_IDX) acked <= !sda_i;
            if (ph == 2'd3) begin
              if (idx == ACK_IDX) st <= S_STOP;
              else idx <= idx + 4'd1;
            end
          end
          S_STOP: if (step) begin
            ph <= ph + 2'd1;
            if (ph == 2'd3) begin
              if (acked || abort)   st <= S_IDLE;
              else if (pause == '0) st <= S_START;
              else                  st <= S_PAUSE;
            end
          end
          S_PAUSE: if (scl_tick && p_last) begin
            st <= S_START; ph <= '0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R5: ready is a single-cycle pulse and polling is over when it shows
  a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  a_r5_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy);
  // R8: a timeout leaves the bus released and the block idle
  a_r8_tmo_release: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!busy && !scl_oe && !sda_oe));
  // R1: an idle block never drives the bus
  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
  // R3: line drive only moves on a tick or an enable change
  a_r3_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !scl_tick) |=> ($stable(scl_oe) && $stable(sda_oe)));
  // R7: never both events at once
  a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timeout));
endmodule

// File: tb/i2c_presence_poller_tb.sv
module i2c_presence_poller_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic       rst_n, en, go;
  logic [6:0] addr;
  logic [3:0] pause;
  logic [7:0] tmo;
  logic       scl_tick, scl_i, sda_i, scl_oe, sda_oe, ready, timeout, busy;
  logic [1:0] tdiv;
  logic       stretch;

  // slave model state
  logic [6:0] slv_addr;
  int         ack_after;
  logic       scl_p, sda_p, ack_low;
  logic [7:0] shreg, last_byte;
  int         bitc, n_start, n_stop, cyc, last_start, interval;
  int         ready_cnt, tmo_cnt;

  int checks = 0, bad = 0;
  bit done = 0;

  assign scl_i = !scl_oe && !stretch;
  assign sda_i = !sda_oe && !ack_low;
  assign scl_tick = (tdiv == 2'd3);

  i2c_presence_poller u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .go(go), .addr(addr), .pause(pause),
    .tmo(tmo), .scl_tick(scl_tick), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready), .timeout(timeout),
    .busy(busy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv <= 0; scl_p <= 1; sda_p <= 1; ack_low <= 0; bitc <= 10;
      shreg <= 0; last_byte <= 0; n_start <= 0; n_stop <= 0; cyc <= 0;
      last_start <= 0; interval <= 0; ready_cnt <= 0; tmo_cnt <= 0;
    end else begin
      tdiv <= tdiv + 2'd1;
      cyc <= cyc + 1;
      scl_p <= scl_i; sda_p <= sda_i;
      if (ready) ready_cnt <= ready_cnt + 1;
      if (timeout) tmo_cnt <= tmo_cnt + 1;
      if (scl_p && scl_i && sda_p && !sda_i) begin
        n_start <= n_start + 1; bitc <= 0;
        interval <= cyc - last_start; last_start <= cyc;
      end else if (scl_p && scl_i && !sda_p && sda_i) begin
        n_stop <= n_stop + 1;
      end else if (!scl_p && scl_i && bitc < 8) begin
        shreg <= {shreg[6:0], sda_i}; bitc <= bitc + 1;
      end else if (scl_p && !scl_i) begin
        if (bitc == 8) begin
          bitc <= 9; last_byte <= shreg;
          ack_low <= (shreg == {slv_addr, 1'b1}) && (n_start > ack_after);
        end else if (bitc == 9) begin
          ack_low <= 0; bitc <= 10;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tickn(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1; @(negedge clk); go = 0;
  endtask

  // {addr, nacks before ack, pause}
  localparam logic [14:0] VEC [4] = '{
    {7'h50, 4'd0, 4'd0},
    {7'h2A, 4'd2, 4'd0},
    {7'h11, 4'd1, 4'd3},
    {7'h7F, 4'd3, 4'd15}
  };

  initial begin
    rst_n = 0; en = 0; go = 0; addr = 0; pause = 0; tmo = 8'hFF;
    stretch = 0; slv_addr = 0; ack_after = 1000000;
    tickn(5);
    chk(!busy && !ready && !timeout && !scl_oe && !sda_oe, "R1 reset state",
        {busy, ready, timeout, scl_oe, sda_oe}, 0);
    @(negedge clk); rst_n = 1;
    tickn(4);
    en = 1;

    for (int v = 0; v < 4; v++) begin
      automatic logic [6:0] a = VEC[v][14:8];
      automatic int nk = int'(VEC[v][7:4]);
      automatic int p = int'(VEC[v][3:0]);
      automatic int s0 = n_start;
      automatic int r0 = ready_cnt;
      automatic int w = 0;
      slv_addr = a; ack_after = s0 + nk; pause = 4'(p); addr = a;
      pulse_go();
      addr = ~a;  // must not matter after go
      while (ready_cnt == r0 && w < 20000) begin tickn(1); w++; end
      chk(ready_cnt == r0 + 1, "R5 ready pulse", ready_cnt - r0, 1);
      chk(!busy, "R5 idle after ack", busy, 0);
      chk(n_start - s0 == nk + 1, "R4 NACK retries", n_start - s0, nk + 1);
      chk(last_byte == {a, 1'b1}, "R3 probe byte", last_byte, {a, 1'b1});
      chk(last_byte == {a, 1'b1}, "R2 address latched", last_byte, {a, 1'b1});
      if (nk > 0)
        chk(interval == 176 + 16 * p, "R4 start interval", interval, 176 + 16 * p);
      tickn(1500);
      chk(n_start - s0 == nk + 1, "R5 no probe after ack", n_start - s0, nk + 1);
    end
    chk(tmo_cnt == 0, "R7 no spurious timeout", tmo_cnt, 0);

    // R6: stretch below the limit, probe still completes
    begin
      automatic int s0 = n_start;
      automatic int r0 = ready_cnt;
      automatic int w = 0;
      tmo = 8'hFF; slv_addr = 7'h33; addr = 7'h33; ack_after = s0; pause = 0;
      pulse_go();
      while (n_start == s0) tickn(1);
      tickn(40);
      stretch = 1; tickn(1500); stretch = 0;
      while (ready_cnt == r0 && w < 5000) begin tickn(1); w++; end
      chk(ready_cnt == r0 + 1, "R6 stretched probe completes", ready_cnt - r0, 1);
      chk(tmo_cnt == 0, "R6 short stretch no timeout", tmo_cnt, 0);
    end

    // R7/R8: stretch beyond a short limit
    begin
      automatic int s0 = n_start;
      automatic int t0 = tmo_cnt;
      automatic int c0 = 0;
      automatic int w = 0;
      tmo = 8'd3; ack_after = 1000000; pause = 0;
      pulse_go();
      while (n_start == s0) tickn(1);
      tickn(40);
      stretch = 1;
      while (scl_oe && w < 100) begin tickn(1); w++; end
      c0 = cyc;
      w = 0;
      while (tmo_cnt == t0 && w < 2000) begin tickn(1); w++; end
      chk(tmo_cnt == t0 + 1, "R7 timeout pulse", tmo_cnt - t0, 1);
      chk(cyc - c0 >= 60 && cyc - c0 <= 70, "R7 timeout delay", cyc - c0, 64);
      chk(!busy && !scl_oe && !sda_oe, "R8 released after timeout",
          {busy, scl_oe, sda_oe}, 0);
      stretch = 0;
      tickn(1500);
      chk(n_start == s0 + 1, "R8 no probe after timeout", n_start - s0, 1);
    end

    // R9: disable mid-probe
    begin
      automatic int s0 = n_start;
      automatic int p0 = n_stop;
      automatic int r0 = ready_cnt;
      tmo = 8'hFF; ack_after = 1000000;
      pulse_go();
      while (n_start == s0) tickn(1);
      tickn(60);
      en = 0;
      tickn(300);
      chk(n_stop == p0 + 1, "R9 stop on abort", n_stop - p0, 1);
      chk(!busy && !scl_oe && !sda_oe, "R9 idle after abort",
          {busy, scl_oe, sda_oe}, 0);
      chk(ready_cnt == r0, "R9 no ready on abort", ready_cnt - r0, 0);
      pulse_go();
      tickn(400);
      chk(!busy && n_start == s0 + 1, "R2 go ignored when disabled",
          n_start - s0, 1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule